// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip trace sink. A stream of 32-bit trace words, each marked by a valid strobe, is written into a circular RAM while capture is enabled. Software later drains the RAM through a register interface (write strobe, read strobe, address, 32-bit data), one word per read of an auto-incrementing data port. The same interface lets software seed or clear the RAM through an auto-incrementing write port and move both pointers directly.

Capture can end in two ways. Either a trigger input arms a post-trigger word counter that halts capture once it runs out, or software requests a manual flush. In both cases the block pads the RAM with zero words until the write pointer sits on a 4-word frame boundary, and only then reports itself stopped. A full flag set on write-pointer wrap tells software whether the oldest word sits at address 0 or at the write pointer.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset the depth register (offset 0x004) reads DEPTH; status (0x00C, bit 0 = full), read pointer (0x014), write pointer (0x018), trigger count (0x01C) and control (0x020, bit 0 = capture enable) read 0; stop status (0x300) reads 2, because bit 1 = stopped also reads 1 while capture is disabled.
- R2: Each write to the write-data port (0x024) stores the word at the write pointer and advances the pointer by one.
- R3: Each read of the read-data port (0x010) returns the word at the read pointer on reg_rdata one cycle after the strobe, and advances the read pointer by one. Any register read returns its value one cycle after the strobe.
- R4: Software can load and read back both pointers. Both pointers wrap from DEPTH-1 to 0.
- R5: A trace word with trc_valid high is stored at the write pointer only while control bit 0 is 1 and the block is not stopped. Otherwise it is ignored, and the write pointer does not move.
- R6: The full flag (0x00C bit 0) becomes 1 when any store wraps the write pointer from DEPTH-1 to 0. Any software write to 0x018 clears it.
- R7: Setting bit 6 of the stop-control register (0x304) starts a flush. During the flush, trace input is ignored and zero words are stored until the write pointer is a multiple of 4. Bit 6 then reads back 0. If bit 12 is set, the block also becomes stopped.
- R8: With 0x304 bit 13 set and capture running, a trigger arms the block. Every trace word stored from the trigger cycle on decrements the trigger count. When the count reads zero, capture pads with zeros to a 4-word boundary and then stops, shown by 0x300 bit 1 = 1.
- R9: A trigger while 0x304 bit 13 is 0 has no effect: capture continues and the trigger count does not change.
- R10: A software write to 0x018 or 0x024 wins over a trace word arriving in the same cycle. That trace word is dropped.
- R11: Writing the control register with bit 0 = 1 clears the stopped state and any armed trigger or pending pad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger event |

## Verification
Two paths compete for the write pointer and the RAM port in the same cycle: the capture path, which stores a trace word or a pad word, and software writes to the write-pointer or write-data register. The bench drives trc_valid in the same cycle as each kind of software write. It then judges the outcome at the ports. The pointer must read back the software value, and a sentinel word placed at the old pointer must survive when read through the auto-incrementing data port.

// File: rtl/trace_ring_buf.sv
module trace_ring_buf #(
  parameter int DEPTH       = 64,
  parameter int FRAME_WORDS = 4,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              trc_valid,
  input  logic [31:0]       trc_data,
  input  logic              trc_trigger
);
  localparam int PW = $clog2(DEPTH);
  localparam int FW = $clog2(FRAME_WORDS);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  localparam logic [ADDR_W-1:0] A_DEPTH = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h00C);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] A_RPTR  = ADDR_W'('h014);
  localparam logic [ADDR_W-1:0] A_WPTR  = ADDR_W'('h018);
  localparam logic [ADDR_W-1:0] A_TCNT  = ADDR_W'('h01C);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h020);
  localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'('h024);
  localparam logic [ADDR_W-1:0] A_HSTAT = ADDR_W'('h300);
  localparam logic [ADDR_W-1:0] A_HCTRL = ADDR_W'('h304);

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, cap_en, fmt_en, flush_req, stop_on_flush, stop_on_trig;
  logic          stopped, armed, drain;
  logic [31:0]   trig_cnt;

  wire sw_wptr  = reg_wr && reg_addr == A_WPTR;
  wire sw_wdata = reg_wr && reg_addr == A_WDATA;
  wire sw_rptr  = reg_wr && reg_addr == A_RPTR;
  wire sw_tcnt  = reg_wr && reg_addr == A_TCNT;
  wire sw_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire sw_hctrl = reg_wr && reg_addr == A_HCTRL;
  wire rd_adv   = reg_rd && reg_addr == A_RDATA;
  wire restart  = sw_ctrl && reg_wdata[0];

  wire sw_owns  = sw_wptr || sw_wdata;
  wire live     = cap_en && !stopped;
  wire aligned  = wr_ptr[FW-1:0] == '0;
  wire busy     = drain || flush_req;
  wire cnt_zero = trig_cnt == '0;
  wire trig_hit = trc_trigger && stop_on_trig && live && !armed && !drain;
  wire counting = armed || trig_hit;

  wire trc_acc  = live && trc_valid && !busy && !(counting && cnt_zero) && !sw_owns;
  wire pad      = live && busy && !aligned && !sw_owns;
  wire mem_we   = trc_acc || pad || sw_wdata;
  wire [31:0] mem_wd = sw_wdata ? reg_wdata : (pad ? 32'd0 : trc_data);
  wire settle   = busy && (aligned || !live);
  wire expire   = armed && cnt_zero && !drain;

  wire [PW-1:0] wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  wire [PW-1:0] rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;

  always_ff @(posedge clk)
    if (mem_we) mem[wr_ptr] <= mem_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr        <= '0;
      rd_ptr        <= '0;
      full          <= 1'b0;
      cap_en        <= 1'b0;
      fmt_en        <= 1'b0;
      flush_req     <= 1'b0;
      stop_on_flush <= 1'b0;
      stop_on_trig  <= 1'b0;
      stopped       <= 1'b0;
      armed         <= 1'b0;
      drain         <= 1'b0;
      trig_cnt      <= '0;
      reg_rdata     <= '0;
    end else begin
      if (sw_wptr)     wr_ptr <= reg_wdata[PW-1:0];
      else if (mem_we) wr_ptr <= wr_nxt;

      if (sw_wptr)                        full <= 1'b0;
      else if (mem_we && wr_ptr == LAST)  full <= 1'b1;

      if (sw_rptr)     rd_ptr <= reg_wdata[PW-1:0];
      else if (rd_adv) rd_ptr <= rd_nxt;

      if (sw_ctrl) cap_en <= reg_wdata[0];

      if (sw_hctrl) begin
        fmt_en        <= reg_wdata[0];
        flush_req     <= reg_wdata[6];
        stop_on_flush <= reg_wdata[12];
        stop_on_trig  <= reg_wdata[13];
      end else if (settle) begin
        flush_req <= 1'b0;
      end

      if (restart)
        stopped <= 1'b0;
      else if (settle && (drain || (flush_req && stop_on_flush)))
        stopped <= 1'b1;

      if (restart)      drain <= 1'b0;
      else if (expire)  drain <= 1'b1;
      else if (settle)  drain <= 1'b0;

      if (restart || expire) armed <= 1'b0;
      else if (trig_hit)     armed <= 1'b1;

      if (sw_tcnt)                               trig_cnt <= reg_wdata;
      else if (trc_acc && counting && !cnt_zero) trig_cnt <= trig_cnt - 1'b1;

      if (reg_rd) begin
        unique case (reg_addr)
          A_DEPTH: reg_rdata <= 32'(DEPTH);
          A_STAT:  reg_rdata <= {31'd0, full};
          A_RDATA: reg_rdata <= mem[rd_ptr];
          A_RPTR:  reg_rdata <= 32'(rd_ptr);
          A_WPTR:  reg_rdata <= 32'(wr_ptr);
          A_TCNT:  reg_rdata <= trig_cnt;
          A_CTRL:  reg_rdata <= {31'd0, cap_en};
          A_HSTAT: reg_rdata <= {30'd0, stopped || !cap_en, 1'b0};
          A_HCTRL: reg_rdata <= {18'd0, stop_on_trig, stop_on_flush, 5'd0,
                                 flush_req, 5'd0, fmt_en};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/trace_ring_buf_chk.sv
module trace_ring_buf_chk #(
  parameter int DEPTH       = 64,
  parameter int FRAME_WORDS = 4,
  parameter int PW          = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          full,
  input logic          cap_en,
  input logic          stopped,
  input logic          mem_we,
  input logic [31:0]   trig_cnt
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  a_r4_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(wr_ptr) < DEPTH) && (32'(rd_ptr) < DEPTH));

  a_r6_wrap_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wr_ptr == LAST) |=> (full && wr_ptr == '0));

  a_r5_idle_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !reg_wr) |=> $stable(wr_ptr));

  a_r8_stopped_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !reg_wr) |=> $stable(wr_ptr));

  a_r8_stop_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stopped) && $past(cap_en) && !$past(reg_wr))
      |-> (32'(wr_ptr) % FRAME_WORDS == 0));

  a_r8_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> trig_cnt <= $past(trig_cnt));
endmodule

bind trace_ring_buf trace_ring_buf_chk #(
  .DEPTH(DEPTH), .FRAME_WORDS(FRAME_WORDS), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .full(full), .cap_en(cap_en), .stopped(stopped), .mem_we(mem_we),
  .trig_cnt(trig_cnt)
);

// File: tb/trace_ring_buf_tb.sv
module trace_ring_buf_tb;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        trc_valid = 1'b0, trc_trigger = 1'b0;
  logic [31:0] trc_data = '0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  trace_ring_buf #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trc_valid(trc_valid), .trc_data(trc_data), .trc_trigger(trc_trigger)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d, input logic trg);
    @(negedge clk);
    trc_valid = 1'b1; trc_data = d; trc_trigger = trg;
    @(negedge clk);
    trc_valid = 1'b0; trc_trigger = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd('h004, v); chk("R1 depth", v, DEPTH);
    rd('h00C, v); chk("R1 status", v, 0);
    rd('h014, v); chk("R1 rptr", v, 0);
    rd('h018, v); chk("R1 wptr", v, 0);
    rd('h01C, v); chk("R1 tcnt", v, 0);
    rd('h020, v); chk("R1 ctrl", v, 0);
    rd('h300, v); chk("R1 stop status", v, 2);
  endtask

  task automatic t_sw_fill;
    logic [31:0] v;
    wr('h018, 0);
    for (int i = 0; i < DEPTH; i++) wr('h024, 32'hA500_0000 + i);
    rd('h018, v); chk("R4 wptr wrapped", v, 0);
    rd('h00C, v); chk("R6 full after wrap", v, 1);
    wr('h018, 0);
    rd('h00C, v); chk("R6 full cleared", v, 0);
    wr('h014, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd('h010, v); chk("R2 R3 dump word", v, 32'hA500_0000 + i);
    end
    rd('h014, v); chk("R4 rptr wrapped", v, 0);
    wr('h014, 5);
    rd('h014, v); chk("R4 rptr load", v, 5);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    wr('h304, 'h1);
    wr('h018, DEPTH - 2);
    wr('h020, 1);
    push(32'h1111, 0); push(32'h2222, 0); push(32'h3333, 0);
    rd('h018, v); chk("R5 wptr after capture", v, 1);
    rd('h00C, v); chk("R6 full on capture wrap", v, 1);
    wr('h014, DEPTH - 2);
    rd('h010, v); chk("R5 word0", v, 32'h1111);
    rd('h010, v); chk("R5 word1", v, 32'h2222);
    rd('h010, v); chk("R5 word2", v, 32'h3333);
    wr('h020, 0);
    push(32'h4444, 0);
    rd('h018, v); chk("R5 disabled ignores trace", v, 1);
  endtask

  task automatic t_trigger;
    logic [31:0] v;
    wr('h304, 'h2001);
    wr('h01C, 5);
    wr('h018, 0);
    wr('h020, 1);
    for (int i = 0; i < 3; i++) push(32'hB0 + i, 0);
    push(32'hB3, 1);
    for (int i = 4; i < 8; i++) push(32'hB0 + i, 0);
    idle(4);
    rd('h01C, v); chk("R8 count exhausted", v, 0);
    rd('h300, v); chk("R8 stopped", v, 2);
    push(32'hFF, 0);
    rd('h018, v); chk("R8 stopped ignores trace", v, 8);
    wr('h020, 1);
    rd('h300, v); chk("R11 restart clears stop", v, 0);
    wr('h01C, 2);
    wr('h018, 0);
    push(32'hC0, 0); push(32'hC1, 1); push(32'hC2, 0);
    idle(4);
    rd('h018, v); chk("R8 padded to frame", v, 4);
    rd('h300, v); chk("R8 stopped unaligned", v, 2);
    wr('h014, 0);
    rd('h010, v); chk("R8 pre word", v, 32'hC0);
    rd('h010, v); chk("R8 trig word", v, 32'hC1);
    rd('h010, v); chk("R8 post word", v, 32'hC2);
    rd('h010, v); chk("R8 pad word zero", v, 0);
  endtask

  task automatic t_no_stop_trigger;
    logic [31:0] v;
    wr('h304, 'h1);
    wr('h020, 1);
    wr('h01C, 1);
    wr('h018, 0);
    push(32'hD0, 1);
    for (int i = 1; i < 6; i++) push(32'hD0 + i, 0);
    idle(3);
    rd('h018, v); chk("R9 capture continues", v, 6);
    rd('h01C, v); chk("R9 count unchanged", v, 1);
    rd('h300, v); chk("R9 not stopped", v, 0);
  endtask

  task automatic t_flush;
    logic [31:0] v;
    wr('h304, 'h1001);
    wr('h020, 1);
    wr('h018, 0);
    push(32'hE0, 0); push(32'hE1, 0);
    wr('h304, 'h1041);
    idle(5);
    rd('h304, v); chk("R7 flush bit self-clears", v, 'h1001);
    rd('h018, v); chk("R7 padded wptr", v, 4);
    rd('h300, v); chk("R7 stopped after flush", v, 2);
    wr('h014, 2);
    rd('h010, v); chk("R7 pad word2", v, 0);
    rd('h010, v); chk("R7 pad word3", v, 0);
    push(32'hEE, 0);
    rd('h018, v); chk("R7 stopped ignores trace", v, 4);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr('h304, 'h1);
    wr('h020, 1);
    wr('h018, 6);
    wr('h024, 32'h5EA7_0006);
    wr('h018, 6);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 'h018; reg_wdata = 'h10;
    trc_valid = 1'b1; trc_data = 32'hBAD0_0001;
    @(negedge clk);
    reg_wr = 1'b0; trc_valid = 1'b0;
    rd('h018, v); chk("R10 pointer write wins", v, 'h10);
    wr('h014, 6);
    rd('h010, v); chk("R10 sentinel kept", v, 32'h5EA7_0006);
    wr('h018, 'h20);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 'h024; reg_wdata = 32'h5EA7_0020;
    trc_valid = 1'b1; trc_data = 32'hBAD0_0002;
    @(negedge clk);
    reg_wr = 1'b0; trc_valid = 1'b0;
    rd('h018, v); chk("R10 single advance", v, 'h21);
    wr('h014, 'h20);
    rd('h010, v); chk("R10 data write wins", v, 32'h5EA7_0020);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_sw_fill();
    t_capture();
    t_trigger();
    t_no_stop_trigger();
    t_flush();
    t_collide();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule